// File: doc/BRIEF.md
# Ethernet Transmit Descriptor Engine

This block sits on the DMA side of an Ethernet transmit path and walks a list of transmit descriptors that software has placed in system memory. From a poll-demand pulse it fetches one descriptor at a time over a single request/acknowledge memory port. It checks the ownership flag and hands the two buffer pointers, their byte counts and the per-channel control bits to a downstream frame mover. When the mover reports that the frame has gone, the engine writes the status word back. When a timestamp was captured and extended descriptors are selected, it also writes the timestamp.

Descriptors are either 16 bytes (normal) or 32 bytes (extended). The size is selected by a mode input that is sampled each time a new descriptor fetch begins. The list is either a ring of consecutive descriptors, with a wrap flag that returns to the base address, or a chain in which the fourth word points at the next descriptor. When the engine finds a descriptor that it does not own, it parks in a suspended state until software issues another poll demand. It then re-reads the same descriptor.

Top module: `txd_engine`

## Requirements
- R1: Every descriptor fetch is exactly four 32-bit reads at offsets 0, 4, 8 and 12 from the descriptor address, in that order, in both descriptor sizes.
- R2: With normal descriptors the engine never reads or writes offsets 16 to 31 of a descriptor. With extended descriptors it only writes there, and only at offsets 24 and 28.
- R3: Buffer 1 length is word 1 bits [12:0]. Buffer 2 length is word 1 bits [28:16].
- R4: Buffer 1 address is word 2. Buffer 2 address is word 3, except when the chain flag (word 0 bit 20) is set. In that case buffer 2 address and length are both presented as zero.
- R5: The 4-bit frame control output carries word 0 bits [6:3] when the channel number is 1 or 2, and zero for channel 0 or 3.
- R6: A descriptor is handed to the mover only when word 0 bit 31 (owned) is set. The status writeback clears bit 31 and keeps every other bit of word 0 except bits 17 and 15.
- R7: A fetched descriptor whose bit 31 is clear raises suspend. While suspended there are no memory requests and no offers. A kick pulse then re-reads the same descriptor address.
- R8: The next descriptor address is word 3 when the chain flag is set. Otherwise it is the base address when the wrap flag (word 0 bit 21) is set. Otherwise it is the current address plus 16 (normal) or plus 32 (extended). Chain takes precedence over wrap.
- R9: In extended mode, a frame completed with a valid timestamp writes the low word at offset 24, the high word at offset 28, and sets bit 17 of word 0. In normal mode, or without a timestamp, bit 17 is written as 0 and no timestamp writes occur.
- R10: Writeback order is word 0, then offset 24, then offset 28. All writebacks finish before the first read of the next descriptor.
- R11: The error flag reported with frame completion is written into word 0 bit 15.
- R12: A memory request keeps address, direction and write data stable until acknowledged. An offer keeps its fields stable until the mover accepts it.
- R13: After reset the engine is idle, with no request, no offer and no suspend. Its first fetch after a kick starts at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Poll-demand pulse: start from idle or resume from suspend |
| ext_mode | input | 1 | 1 selects 32-byte extended descriptors |
| chan_id | input | 2 | Channel number served by this engine |
| base_addr | input | AW | Descriptor list base address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| frm_valid | output | 1 | Descriptor fields offered to frame mover |
| frm_ready | input | 1 | Mover accepts the offer |
| buf1_addr | output | AW | Buffer 1 address |
| buf1_len | output | 13 | Buffer 1 byte count |
| buf2_addr | output | AW | Buffer 2 address (zero when chained) |
| buf2_len | output | 13 | Buffer 2 byte count (zero when chained) |
| frm_ctrl | output | 4 | Per-channel control bits |
| frm_done | input | 1 | Frame finished pulse |
| done_ts_valid | input | 1 | Timestamp captured for this frame |
| done_err | input | 1 | Frame ended with an error |
| done_ts_lo | input | 32 | Timestamp low word |
| done_ts_hi | input | 32 | Timestamp high word |
| suspend | output | 1 | Stopped on a descriptor not owned by the engine |

## Verification
The assertions watch the bus discipline on every cycle: each access must stay within the 16-byte fetch window or the two timestamp slots of the current descriptor, and no slot beyond 16 bytes may be touched in normal mode. Requests and offers must hold steady until acknowledged, a status write must always clear ownership, and the engine must stay quiet while suspended. Only the bench scenarios show the values themselves. These are the fields extracted per channel, the exact bits of the written-back status word, the chain, wrap and stride choice of the next address, the ordering of writebacks ahead of the next fetch, and the re-read of the same descriptor after a poll demand.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int DATA_W      = 32;
    localparam int FETCH_WORDS = 4;
    localparam int LEN_W       = 13;
    localparam int CTRL_W      = 4;

    // word 0 bit positions
    localparam int OWN_BIT   = 31;
    localparam int WRAP_BIT  = 21;
    localparam int CHAIN_BIT = 20;
    localparam int TSS_BIT   = 17;
    localparam int ERR_BIT   = 15;
    localparam int CTRL_LSB  = 3;

    // word 1 field positions
    localparam int LEN1_LSB = 0;
    localparam int LEN2_LSB = 16;

    // byte offsets / strides
    localparam int NORM_STRIDE = 16;
    localparam int EXT_STRIDE  = 32;
    localparam int TS_LO_OFF   = 24;
    localparam int TS_HI_OFF   = 28;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_SUSP,
        ST_OFFER,
        ST_WAIT,
        ST_WB0,
        ST_WBLO,
        ST_WBHI,
        ST_ADV
    } seq_state_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              chain;
        logic              wrap;
        logic [LEN_W-1:0]  len1;
        logic [LEN_W-1:0]  len2;
    } desc_fields_t;

    function automatic logic [DATA_W-1:0] status_word(
        input logic [DATA_W-1:0] w0,
        input logic              ts_written,
        input logic              err
    );
        logic [DATA_W-1:0] w;
        w          = w0;
        w[OWN_BIT] = 1'b0;
        w[TSS_BIT] = ts_written;
        w[ERR_BIT] = err;
        return w;
    endfunction

endpackage

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic              ext_mode,
    input  logic [AW-1:0]     base_addr,
    input  logic [AW-1:0]     nxt_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              frm_valid,
    input  logic              frm_ready,
    input  logic              frm_done,
    input  logic              done_ts_valid,
    input  logic              done_err,
    input  logic [DATA_W-1:0] done_ts_lo,
    input  logic [DATA_W-1:0] done_ts_hi,
    output logic              suspend,
    output desc_fields_t      fields,
    output logic [AW-1:0]     ptr_a,
    output logic [AW-1:0]     ptr_b,
    output logic [AW-1:0]     cur_addr,
    output logic              ext_lat
);

    localparam int IDX_W = $clog2(FETCH_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FETCH_WORDS - 1);

    seq_state_e        st;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] w0_q;
    logic [LEN_W-1:0]  len1_q, len2_q;
    logic [AW-1:0]     pa_q, pb_q;
    logic [AW-1:0]     cur_q;
    logic              ext_q;
    logic              ts_q, err_q;
    logic [DATA_W-1:0] ts_lo_q, ts_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            idx     <= '0;
            w0_q    <= '0;
            len1_q  <= '0;
            len2_q  <= '0;
            pa_q    <= '0;
            pb_q    <= '0;
            cur_q   <= '0;
            ext_q   <= 1'b0;
            ts_q    <= 1'b0;
            err_q   <= 1'b0;
            ts_lo_q <= '0;
            ts_hi_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (kick) begin
                        cur_q <= base_addr;
                        ext_q <= ext_mode;
                        idx   <= '0;
                        st    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        unique case (idx)
                            IDX_W'(0): w0_q <= mem_rdata;
                            IDX_W'(1): begin
                                len1_q <= mem_rdata[LEN1_LSB +: LEN_W];
                                len2_q <= mem_rdata[LEN2_LSB +: LEN_W];
                            end
                            IDX_W'(2): pa_q <= mem_rdata[AW-1:0];
                            default:   pb_q <= mem_rdata[AW-1:0];
                        endcase
                        if (idx == LAST_IDX) st <= ST_EVAL;
                        else                 idx <= idx + 1'b1;
                    end
                end
                ST_EVAL: st <= w0_q[OWN_BIT] ? ST_OFFER : ST_SUSP;
                ST_SUSP: begin
                    if (kick) begin
                        idx   <= '0;
                        ext_q <= ext_mode;
                        st    <= ST_FETCH;
                    end
                end
                ST_OFFER: if (frm_ready) st <= ST_WAIT;
                ST_WAIT: begin
                    if (frm_done) begin
                        ts_q    <= ext_q & done_ts_valid;
                        err_q   <= done_err;
                        ts_lo_q <= done_ts_lo;
                        ts_hi_q <= done_ts_hi;
                        st      <= ST_WB0;
                    end
                end
                ST_WB0:  if (mem_ack) st <= ts_q ? ST_WBLO : ST_ADV;
                ST_WBLO: if (mem_ack) st <= ST_WBHI;
                ST_WBHI: if (mem_ack) st <= ST_ADV;
                ST_ADV: begin
                    cur_q <= nxt_addr;
                    ext_q <= ext_mode;
                    idx   <= '0;
                    st    <= ST_FETCH;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        unique case (st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({idx, 2'b00});
            end
            ST_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = status_word(w0_q, ts_q, err_q);
            end
            ST_WBLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + AW'(TS_LO_OFF);
                mem_wdata = ts_lo_q;
            end
            ST_WBHI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + AW'(TS_HI_OFF);
                mem_wdata = ts_hi_q;
            end
            default: ;
        endcase
    end

    assign frm_valid    = (st == ST_OFFER);
    assign suspend      = (st == ST_SUSP);
    assign fields.ctrl  = w0_q[CTRL_LSB +: CTRL_W];
    assign fields.chain = w0_q[CHAIN_BIT];
    assign fields.wrap  = w0_q[WRAP_BIT];
    assign fields.len1  = len1_q;
    assign fields.len2  = len2_q;
    assign ptr_a        = pa_q;
    assign ptr_b        = pb_q;
    assign cur_addr     = cur_q;
    assign ext_lat      = ext_q;

endmodule

// File: rtl/txd_decode.sv
module txd_decode
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  desc_fields_t      fields,
    input  logic [AW-1:0]     ptr_a,
    input  logic [AW-1:0]     ptr_b,
    input  logic [1:0]        chan_id,
    output logic [AW-1:0]     buf1_addr,
    output logic [LEN_W-1:0]  buf1_len,
    output logic [AW-1:0]     buf2_addr,
    output logic [LEN_W-1:0]  buf2_len,
    output logic [CTRL_W-1:0] frm_ctrl
);

    logic ctrl_live;

    assign ctrl_live = (chan_id == 2'd1) || (chan_id == 2'd2);

    assign buf1_addr = ptr_a;
    assign buf1_len  = fields.len1;
    assign buf2_addr = fields.chain ? '0 : ptr_b;
    assign buf2_len  = fields.chain ? '0 : fields.len2;
    assign frm_ctrl  = ctrl_live ? fields.ctrl : '0;

endmodule

// File: rtl/txd_next.sv
module txd_next
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] link_ptr,
    input  logic          ext_lat,
    input  logic          chain,
    input  logic          wrap,
    output logic [AW-1:0] nxt_addr
);

    localparam logic [AW-1:0] STEP_N = AW'(NORM_STRIDE);
    localparam logic [AW-1:0] STEP_E = AW'(EXT_STRIDE);

    always_comb begin
        if (chain)     nxt_addr = link_ptr;
        else if (wrap) nxt_addr = base_addr;
        else           nxt_addr = cur_addr + (ext_lat ? STEP_E : STEP_N);
    end

endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic              ext_mode,
    input  logic [1:0]        chan_id,
    input  logic [AW-1:0]     base_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [AW-1:0]     buf1_addr,
    output logic [12:0]       buf1_len,
    output logic [AW-1:0]     buf2_addr,
    output logic [12:0]       buf2_len,
    output logic [3:0]        frm_ctrl,
    input  logic              frm_done,
    input  logic              done_ts_valid,
    input  logic              done_err,
    input  logic [31:0]       done_ts_lo,
    input  logic [31:0]       done_ts_hi,
    output logic              suspend
);

    desc_fields_t  fields;
    logic [AW-1:0] ptr_a, ptr_b;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] nxt_addr;
    logic          ext_lat;

    txd_seq #(.AW(AW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .kick          (kick),
        .ext_mode      (ext_mode),
        .base_addr     (base_addr),
        .nxt_addr      (nxt_addr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .frm_valid     (frm_valid),
        .frm_ready     (frm_ready),
        .frm_done      (frm_done),
        .done_ts_valid (done_ts_valid),
        .done_err      (done_err),
        .done_ts_lo    (done_ts_lo),
        .done_ts_hi    (done_ts_hi),
        .suspend       (suspend),
        .fields        (fields),
        .ptr_a         (ptr_a),
        .ptr_b         (ptr_b),
        .cur_addr      (cur_addr),
        .ext_lat       (ext_lat)
    );

    txd_decode #(.AW(AW)) u_dec (
        .fields    (fields),
        .ptr_a     (ptr_a),
        .ptr_b     (ptr_b),
        .chan_id   (chan_id),
        .buf1_addr (buf1_addr),
        .buf1_len  (buf1_len),
        .buf2_addr (buf2_addr),
        .buf2_len  (buf2_len),
        .frm_ctrl  (frm_ctrl)
    );

    txd_next #(.AW(AW)) u_nxt (
        .cur_addr  (cur_addr),
        .base_addr (base_addr),
        .link_ptr  (ptr_b),
        .ext_lat   (ext_lat),
        .chain     (fields.chain),
        .wrap      (fields.wrap),
        .nxt_addr  (nxt_addr)
    );

endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          frm_valid,
    input logic          frm_ready,
    input logic [AW-1:0] buf1_addr,
    input logic [12:0]   buf1_len,
    input logic [AW-1:0] buf2_addr,
    input logic          suspend,
    input logic [AW-1:0] cur_addr,
    input logic          ext_lat
);

    logic [AW-1:0] off;
    assign off = mem_addr - cur_addr;

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_offer_hold_r12: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !frm_ready |=> frm_valid && $stable(buf1_addr) && $stable(buf1_len) && $stable(buf2_addr));

    p_fetch_window_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> (off < AW'(16)) && (off[1:0] == 2'b00));

    p_norm_bounds_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && !ext_lat |-> off < AW'(16));

    p_wb_slots_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> (off == '0) || (ext_lat && (off == AW'(24) || off == AW'(28))));

    p_own_clear_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && (off == '0) |-> !mem_wdata[31]);

    p_susp_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        suspend |-> !mem_req && !frm_valid);

    p_offer_excl_r10: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> !mem_req);

endmodule

bind txd_engine txd_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .buf1_addr (buf1_addr),
    .buf1_len  (buf1_len),
    .buf2_addr (buf2_addr),
    .suspend   (suspend),
    .cur_addr  (cur_addr),
    .ext_lat   (ext_lat)
);

// File: tb/txd_engine_tb.sv
module txd_engine_tb;

    localparam logic [31:0] BASE = 32'h40;
    localparam logic [31:0] FILL = 32'h5A5A_5A5A;
    localparam int NVEC = 6;
    // {ext, chain, wrap, ts, err, chan[1:0], ctrl[3:0], 3'b0, len2[12:0], 3'b0, len1[12:0]}
    localparam logic [42:0] VECS [0:NVEC-1] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'hA, 3'b0, 13'h0040, 3'b0, 13'h05EA},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 4'h5, 3'b0, 13'h1FFF, 3'b0, 13'h1FFF},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, 3'b0, 13'h0000, 3'b0, 13'h0001},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 4'h3, 3'b0, 13'h004D, 3'b0, 13'h0064},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 4'h1, 3'b0, 13'h0123, 3'b0, 13'h0456},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 4'h8, 3'b0, 13'h1000, 3'b0, 13'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kick = 1'b0;
    logic        ext_mode = 1'b0;
    logic [1:0]  chan_id = 2'd1;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        frm_valid;
    logic        frm_ready = 1'b0;
    logic [31:0] buf1_addr, buf2_addr;
    logic [12:0] buf1_len, buf2_len;
    logic [3:0]  frm_ctrl;
    logic        frm_done = 1'b0;
    logic        done_ts_valid = 1'b0;
    logic        done_err = 1'b0;
    logic [31:0] done_ts_lo = '0, done_ts_hi = '0;
    logic        suspend;

    logic [31:0] mem [0:63];
    logic [31:0] acc_addr [0:63];
    logic        acc_we [0:63];
    int          acc_n;
    int          n_offer;
    int          done_cnt;
    logic [31:0] cap_b1a, cap_b2a;
    logic [12:0] cap_b1l, cap_b2l;
    logic [3:0]  cap_ctl;
    int          n_tests = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    txd_engine u_dut (
        .clk(clk), .rst(rst), .kick(kick), .ext_mode(ext_mode), .chan_id(chan_id),
        .base_addr(BASE), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .buf1_addr(buf1_addr),
        .buf1_len(buf1_len), .buf2_addr(buf2_addr), .buf2_len(buf2_len),
        .frm_ctrl(frm_ctrl), .frm_done(frm_done), .done_ts_valid(done_ts_valid),
        .done_err(done_err), .done_ts_lo(done_ts_lo), .done_ts_hi(done_ts_hi),
        .suspend(suspend)
    );

    // memory and frame-mover models, updated away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack   = 1'b0;
            frm_ready = 1'b0;
            frm_done  = 1'b0;
            done_cnt  = 0;
        end else begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack = 1'b1;
                if (acc_n < 64) begin
                    acc_addr[acc_n] = mem_addr;
                    acc_we[acc_n]   = mem_we;
                    acc_n++;
                end
                if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[7:2]];
            end
            frm_done = 1'b0;
            if (done_cnt != 0) begin
                done_cnt--;
                if (done_cnt == 0) frm_done = 1'b1;
            end
            if (frm_ready) frm_ready = 1'b0;
            else if (frm_valid) begin
                frm_ready = 1'b1;
                cap_b1a = buf1_addr; cap_b1l = buf1_len;
                cap_b2a = buf2_addr; cap_b2l = buf2_len;
                cap_ctl = frm_ctrl;
                n_offer++;
                done_cnt = 3;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < 64; k++) mem[k] = FILL;
        acc_n = 0;
        n_offer = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic wait_susp();
        for (int k = 0; k < 400; k++) begin
            if (suspend) break;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input int i);
        logic [42:0] v;
        logic ext, chain, wrap, ts, err, tsw, rd_ok, wr_ok, nx_ok;
        logic [1:0] chan;
        logic [3:0] ctrl;
        logic [12:0] l1, l2;
        logic [31:0] w0, w1, w2, w3, nxt, wb;
        int nw;
        v = VECS[i];
        ext = v[42]; chain = v[41]; wrap = v[40]; ts = v[39]; err = v[38];
        chan = v[37:36]; ctrl = v[35:32]; l2 = v[28:16]; l1 = v[12:0];
        w0 = 32'h8000_0200 | {10'b0, wrap, chain, 20'b0} | {25'b0, ctrl, 3'b0};
        w1 = {3'b0, l2, 3'b0, l1};
        w2 = 32'h1000 + 32'(i * 256);
        w3 = chain ? 32'h80 : 32'h2000 + 32'(i);
        do_reset();
        ext_mode = ext; chan_id = chan;
        done_ts_valid = ts; done_err = err;
        done_ts_lo = 32'h1111_0000 + 32'(i);
        done_ts_hi = 32'h2222_0000 + 32'(i);
        mem[16] = w0; mem[17] = w1; mem[18] = w2; mem[19] = w3;
        pulse_kick();
        wait_susp();
        tsw = ext & ts;
        nw  = tsw ? 3 : 1;
        nxt = chain ? 32'h80 : (wrap ? BASE : BASE + (ext ? 32'd32 : 32'd16));
        wb  = (w0 & ~32'h8000_0000) | {14'b0, tsw, 17'b0} | {16'b0, err, 15'b0};
        chk($sformatf("R13 vec%0d suspend reached", i), 64'(suspend), 64'd1);
        chk($sformatf("R6 vec%0d one offer", i), 64'(n_offer), 64'd1);
        chk($sformatf("R3 vec%0d buf1 len", i), 64'(cap_b1l), 64'(l1));
        chk($sformatf("R3 R4 vec%0d buf2 len", i), 64'(cap_b2l), chain ? 64'd0 : 64'(l2));
        chk($sformatf("R4 vec%0d buf1 addr", i), 64'(cap_b1a), 64'(w2));
        chk($sformatf("R4 vec%0d buf2 addr", i), 64'(cap_b2a), chain ? 64'd0 : 64'(w3));
        chk($sformatf("R5 vec%0d ctrl", i), 64'(cap_ctl), (chan == 2'd1 || chan == 2'd2) ? 64'(ctrl) : 64'd0);
        rd_ok = 1'b1;
        for (int k = 0; k < 4; k++)
            if (acc_we[k] || acc_addr[k] != BASE + 32'(4 * k)) rd_ok = 1'b0;
        chk($sformatf("R1 vec%0d fetch reads", i), 64'(rd_ok), 64'd1);
        wr_ok = acc_we[4] && acc_addr[4] == BASE;
        if (tsw) wr_ok = wr_ok && acc_we[5] && acc_addr[5] == BASE + 32'd24
                               && acc_we[6] && acc_addr[6] == BASE + 32'd28;
        chk($sformatf("R10 vec%0d writeback order", i), 64'(wr_ok), 64'd1);
        nx_ok = 1'b1;
        for (int k = 0; k < 4; k++)
            if (acc_we[nw + 4 + k] || acc_addr[nw + 4 + k] != nxt + 32'(4 * k)) nx_ok = 1'b0;
        chk($sformatf("R8 vec%0d next fetch at %h", i, nxt), 64'(nx_ok), 64'd1);
        chk($sformatf("R1 R2 vec%0d access count", i), 64'(acc_n), 64'(8 + nw));
        chk($sformatf("R6 R9 R11 vec%0d status word", i), 64'(mem[16]), 64'(wb));
        chk($sformatf("R9 R2 vec%0d ts low slot", i), 64'(mem[22]), tsw ? 64'(done_ts_lo) : 64'(FILL));
        chk($sformatf("R9 R2 vec%0d ts high slot", i), 64'(mem[23]), tsw ? 64'(done_ts_hi) : 64'(FILL));
    endtask

    initial begin
        // R13: reset state and no activity without a kick
        do_reset();
        ext_mode = 1'b0; chan_id = 2'd1; done_ts_valid = 1'b0; done_err = 1'b0;
        chk("R13 reset mem_req", 64'(mem_req), 64'd0);
        chk("R13 reset frm_valid", 64'(frm_valid), 64'd0);
        chk("R13 reset suspend", 64'(suspend), 64'd0);
        repeat (6) @(negedge clk);
        chk("R13 idle without kick", 64'(acc_n), 64'd0);

        // main table
        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R7: not owned, suspend, then poll demand re-reads same address
        do_reset();
        ext_mode = 1'b0; chan_id = 2'd1;
        mem[16] = 32'h0000_0200; mem[17] = 32'h0000_0010;
        mem[18] = 32'h0000_3000; mem[19] = 32'h0000_4000;
        pulse_kick();
        wait_susp();
        chk("R7 suspend on unowned", 64'(suspend), 64'd1);
        chk("R7 four reads before suspend", 64'(acc_n), 64'd4);
        chk("R7 no offer while unowned", 64'(n_offer), 64'd0);
        repeat (10) @(negedge clk);
        chk("R7 quiet while suspended", 64'(acc_n), 64'd4);
        mem[16] = 32'h8000_0200;
        pulse_kick();
        wait_susp();
        chk("R7 refetch same address", 64'(acc_addr[4]), 64'(BASE));
        chk("R7 offer after resume", 64'(n_offer), 64'd1);
        chk("R7 resumed buf1 addr", 64'(cap_b1a), 64'h3000);

        // R8 R10: two-entry ring, wrap on second returns to base
        do_reset();
        ext_mode = 1'b0; chan_id = 2'd2; done_ts_valid = 1'b1; done_err = 1'b0;
        mem[16] = 32'h8000_0000; mem[17] = 32'h0000_0020;
        mem[18] = 32'h0000_5000; mem[19] = 32'h0000_5800;
        mem[20] = 32'h8020_0000; mem[21] = 32'h0000_0030;
        mem[22] = 32'h0000_6000; mem[23] = 32'h0000_6800;
        pulse_kick();
        wait_susp();
        chk("R8 ring two offers", 64'(n_offer), 64'd2);
        chk("R10 first writeback before second fetch", 64'({acc_we[4], acc_addr[4], acc_we[5], acc_addr[5]}),
            64'({1'b1, BASE, 1'b0, BASE + 32'd16}));
        chk("R8 wrap back to base", 64'({acc_we[9], acc_addr[9], acc_we[10], acc_addr[10]}),
            64'({1'b1, BASE + 32'd16, 1'b0, BASE}));
        chk("R9 normal mode ts not flagged", 64'(mem[20]), 64'h0020_0000);
        chk("R8 ring access count", 64'(acc_n), 64'd14);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule